// File: doc/BRIEF.md
# Power-Up Strap Capture with Shared-Pad Handover

This block reads a small set of pads that serve two roles. While power-on reset is held, the pads act as configuration inputs. Each one is pulled to a logic level by a board resistor, or by an internal pull-up when no resistor is fitted. Every pad level passes through a two-stage synchronizer. A per-bank stability counter then confirms that the synchronized levels have held steady for a set number of consecutive clocks.

Once reset is released and the levels are confirmed stable, the block captures them once into a configuration register and raises a valid flag. In the same cycle it enables the output drivers of every shared pad, so the pads can carry clock outputs from then on. The captured bits are decoded into two settings: a spread-spectrum modulation depth for the downstream frequency synthesizer, and a voltage class for the processor-side output buffers. The capture is frozen. Only a new power-on reset clears it.

Top module: `strap_latch_top`

## Requirements
- R1: While `por` is high, `cfg_valid` is 0 and every bit of `pad_oe` is 0. Whenever `cfg_valid` is 0, `pad_oe` is 0.
- R2: After `por` falls, with the pad levels stable for a long time, `cfg_valid` and all bits of `pad_oe` go to 1 at the first clock edge after release.
- R3: The spread code is {pad_in[1], pad_in[0]}. Code 00 gives `spread_tenths`=0 and `spread_on`=0. Code 01 gives 20 (±2.0 %). Code 10 gives 10 (±1.0 %). Code 11 gives 5 (±0.5 %). For codes 01, 10 and 11, `spread_on` is 1.
- R4: `buf_3v3` equals the captured level of pad_in[2]: 0 selects the 2.5 V class and 1 selects the 3.3 V class.
- R5: While `cfg_valid` is 1, changes on `pad_in` have no effect on `spread_tenths`, `spread_on`, `buf_3v3` or `pad_oe`.
- R6: Capture needs the synchronized pad levels to be unchanged for STABLE_CYCLES (default 4) consecutive clocks. A pad change made 2 clocks before release delays `cfg_valid` to the 5th clock edge after release, and the new level is captured.
- R7: All pads high (no straps fitted) gives ±0.5 % spread and the 3.3 V class.
- R8: Raising `por` again clears `cfg_valid` and `pad_oe` at the next clock edge. The next release captures fresh levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| pad_in | input | NPADS | Raw levels seen on the shared pads |
| pad_oe | output | NPADS | Output enable per shared pad |
| spread_tenths | output | 5 | Spread depth in tenths of a percent |
| spread_on | output | 1 | Spread modulation enabled |
| buf_3v3 | output | 1 | Buffer class: 1 = 3.3 V, 0 = 2.5 V |
| cfg_valid | output | 1 | Configuration captured |

## Verification
Two functions can fall in the same cycle: the release of power-on reset and the stability qualification of a pad that has just moved. The bench provokes this by changing the pad pattern two clocks before it drops `por`, so the synchronized change arrives exactly as the release takes effect. It then checks that `cfg_valid` is still low on the fourth clock after release, that it rises on the fifth, and that the captured fields match the new pattern rather than the old one.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PAD_SPR_LO = 0;
    localparam int PAD_SPR_HI = 1;
    localparam int PAD_VCLASS = 2;
    localparam int MIN_PADS   = 3;

    typedef enum logic [1:0] {
        SPR_NONE = 2'b00,
        SPR_2P0  = 2'b01,
        SPR_1P0  = 2'b10,
        SPR_0P5  = 2'b11
    } spread_e;

    typedef enum logic {
        VC_2V5 = 1'b0,
        VC_3V3 = 1'b1
    } vclass_e;

    typedef struct packed {
        spread_e spread;
        vclass_e vclass;
    } strap_cfg_t;

    function automatic logic [4:0] spread_depth(spread_e s);
        case (s)
            SPR_2P0: return 5'd20;
            SPR_1P0: return 5'd10;
            SPR_0P5: return 5'd5;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            chain[b] <= {chain[b][STAGES-2:0], d[b]};
        end
        assign q[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/strap_stable.sv
module strap_stable #(
    parameter int WIDTH  = 3,
    parameter int CYCLES = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] level,
    output logic             steady
);
    localparam int CW  = $clog2(CYCLES + 1);
    localparam int TOP = CYCLES - 1;

    logic [WIDTH-1:0] prev;
    logic [CW-1:0]    run;
    logic             same;

    assign same = (level == prev);

    always_ff @(posedge clk) begin
        prev <= level;
        if (!same)
            run <= '0;
        else if (run < CW'(TOP))
            run <= run + 1'b1;
    end

    assign steady = same && (run >= CW'(TOP));
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int WIDTH = 3
) (
    input  logic                 clk,
    input  logic                 por,
    input  logic                 steady,
    input  logic [WIDTH-1:0]     level,
    output strap_pkg::strap_cfg_t cfg,
    output logic                 valid
);
    import strap_pkg::*;

    logic take;
    assign take = !por && !valid && steady;

    always_ff @(posedge clk) begin
        if (por) begin
            valid <= 1'b0;
            cfg   <= '{spread: SPR_NONE, vclass: VC_2V5};
        end else if (take) begin
            valid      <= 1'b1;
            cfg.spread <= spread_e'({level[PAD_SPR_HI], level[PAD_SPR_LO]});
            cfg.vclass <= vclass_e'(level[PAD_VCLASS]);
        end
    end
endmodule

// File: rtl/strap_latch_top.sv
module strap_latch_top #(
    parameter int NPADS         = 3,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             por,
    input  logic [NPADS-1:0] pad_in,
    output logic [NPADS-1:0] pad_oe,
    output logic [4:0]       spread_tenths,
    output logic             spread_on,
    output logic             buf_3v3,
    output logic             cfg_valid
);
    import strap_pkg::*;

    logic [NPADS-1:0] synced;
    logic             steady;
    strap_cfg_t       cfg;

    strap_sync #(.WIDTH(NPADS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (synced)
    );

    strap_stable #(.WIDTH(NPADS), .CYCLES(STABLE_CYCLES)) u_stable (
        .clk    (clk),
        .level  (synced),
        .steady (steady)
    );

    strap_capture #(.WIDTH(NPADS)) u_cap (
        .clk    (clk),
        .por    (por),
        .steady (steady),
        .level  (synced),
        .cfg    (cfg),
        .valid  (cfg_valid)
    );

    for (genvar p = 0; p < NPADS; p++) begin : g_oe
        assign pad_oe[p] = cfg_valid;
    end

    assign spread_tenths = spread_depth(cfg.spread);
    assign spread_on     = (cfg.spread != SPR_NONE);
    assign buf_3v3       = (cfg.vclass == VC_3V3);
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk #(
    parameter int NPADS = 3
) (
    input logic             clk,
    input logic             por,
    input logic [NPADS-1:0] pad_oe,
    input logic [4:0]       spread_tenths,
    input logic             spread_on,
    input logic             buf_3v3,
    input logic             cfg_valid
);
    assert_oe_low_unless_valid_R1: assert property (@(posedge clk) disable iff (por)
        !cfg_valid |-> (pad_oe == '0));

    assert_oe_with_valid_R2: assert property (@(posedge clk) disable iff (por)
        $rose(cfg_valid) |-> (&pad_oe));

    assert_depth_legal_R3: assert property (@(posedge clk) disable iff (por)
        cfg_valid |-> ((spread_tenths == 5'd0 && !spread_on) ||
                       (spread_on && (spread_tenths == 5'd20 ||
                                      spread_tenths == 5'd10 ||
                                      spread_tenths == 5'd5))));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (por)
        (cfg_valid && $past(cfg_valid)) |->
            ($stable(spread_tenths) && $stable(buf_3v3) && $stable(pad_oe)));
endmodule

bind strap_latch_top strap_latch_chk #(.NPADS(NPADS)) u_chk (
    .clk           (clk),
    .por           (por),
    .pad_oe        (pad_oe),
    .spread_tenths (spread_tenths),
    .spread_on     (spread_on),
    .buf_3v3       (buf_3v3),
    .cfg_valid     (cfg_valid)
);

// File: tb/test_strap_latch_top.sv
module test_strap_latch_top;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         por = 1'b1;
    logic [N-1:0] pad_in = '1;
    logic [N-1:0] pad_oe;
    logic [4:0]   spread_tenths;
    logic         spread_on;
    logic         buf_3v3;
    logic         cfg_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    strap_latch_top #(.NPADS(N)) i_strap_latch_top (
        .clk(clk), .por(por), .pad_in(pad_in), .pad_oe(pad_oe),
        .spread_tenths(spread_tenths), .spread_on(spread_on),
        .buf_3v3(buf_3v3), .cfg_valid(cfg_valid)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int depth_of(int code);
        case (code)
            1: return 20;
            2: return 10;
            3: return 5;
            default: return 0;
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_fields(string req, int pat);
        chk({req, " valid"}, cfg_valid, 1);
        chk({req, " oe"}, pad_oe, 7);
        chk({req, " depth"}, spread_tenths, depth_of(pat & 3));
        chk({req, " spread_on"}, spread_on, (pat & 3) != 0);
        chk({req, " vclass"}, buf_3v3, (pat >> 2) & 1);
    endtask

    initial begin
        tick(12);
        chk("R1 reset valid", cfg_valid, 0);
        chk("R1 reset oe", pad_oe, 0);

        for (int p = 0; p < 8; p++) begin
            por = 1'b1;
            tick(1);
            chk("R8 reassert valid", cfg_valid, 0);
            chk("R8 reassert oe", pad_oe, 0);
            pad_in = N'(p);
            tick(12);
            chk("R1 held valid", cfg_valid, 0);
            chk("R1 held oe", pad_oe, 0);
            por = 1'b0;
            tick(1);
            check_fields(p == 7 ? "R7" : "R2 R3 R4", p);
            pad_in = ~N'(p);
            tick(10);
            check_fields("R5 frozen", p);
        end

        por = 1'b1;
        pad_in = 3'b000;
        tick(12);
        pad_in = 3'b101;
        tick(2);
        por = 1'b0;
        tick(1);
        chk("R6 early", cfg_valid, 0);
        tick(3);
        chk("R6 fourth", cfg_valid, 0);
        chk("R6 fourth oe", pad_oe, 0);
        tick(1);
        check_fields("R6 captured", 5);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule